// File: doc/BRIEF.md
# UART Service Request Router

This block decides who looks after a UART's two FIFOs. Each direction has a two-bit service selector. It can turn the direction off, hand it to the interrupt or polling path, or give it to one of two DMA request lines that both directions share. The block takes the FIFO fill levels and the trigger thresholds and raises the right request on the right output. It never raises a request on a path that the selectors did not choose.

For reception it also watches for a stall. Some words may sit in the receive FIFO below the trigger while nothing new arrives for three word times. When that happens, the interrupt path is told so that software can drain the rest. If both directions claim the same DMA line, neither drives it, and a configuration error is flagged until the selectors are written again.

Top module: `uart_req_router`

## Requirements
- R1: After reset both selectors read as off (code 00). While they stay off, txIrq, rxIrq, dmaReq and cfgErr are all 0.
- R2: A direction set to off (00) gives no interrupt and no DMA request, whatever its levels are.
- R3: With the transmit selector at 01, txIrq is 1 exactly when txLevel <= txTrig.
- R4: With the receive selector at 01, rxIrq is 1 when rxLevel >= rxTrig. It is also 1 while a receive timeout is pending.
- R5: Selector code 10 routes the direction's level condition to dmaReq[0]. Code 11 routes it to dmaReq[1]. A direction in DMA mode never raises its interrupt.
- R6: If both selectors hold the same DMA code, neither drives that line. cfgErr is then 1 from the cycle after the write until a write of a legal pairing.
- R7: With the receive selector at 01, 0 < rxLevel < rxTrig, and no received word, a timeout becomes pending in the cycle after the third wordTick pulse.
- R8: A pulse on rxStrobe (a word was received) restarts the word-time count from zero.
- R9: A pending timeout clears in the cycle after rxStrobe, or once rxLevel is 0.
- R10: While rxFifoReset is 1, the receive level counts as 0. The word-time count and any pending timeout are cleared at the next edge.
- R11: A receive timeout never becomes pending while the receive selector is not 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe for both selectors |
| cfgTxMode | input | 2 | New transmit selector |
| cfgRxMode | input | 2 | New receive selector |
| txLevel | input | LVL_W | Transmit FIFO fill level |
| txTrig | input | LVL_W | Transmit trigger threshold |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| rxTrig | input | LVL_W | Receive trigger threshold |
| wordTick | input | 1 | One pulse per word time |
| rxStrobe | input | 1 | A word entered the receive FIFO |
| rxFifoReset | input | 1 | Receive FIFO is being reset |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |
| dmaReq | output | 2 | Shared DMA request lines 0 and 1 |
| cfgErr | output | 1 | Both directions selected the same DMA line |

## Verification
The embedded assertions check on every cycle the following:
- no DMA line has two sources;
- a configuration error leaves both lines quiet;
- a disabled direction stays silent;
- a FIFO reset, a received word or a non-interrupt receive mode always clears the pending timeout.

Some behaviour shows up only in the bench's scenarios, which a behavioural model follows on every clock:
- the exact tick on which the timeout fires;
- the restart of the count after a received word;
- the trigger boundaries;
- the recovery from an illegal pairing.

// File: rtl/uart_rr_pkg.sv
package uart_rr_pkg;

  typedef enum logic [1:0] {
    SVC_OFF  = 2'b00,
    SVC_IRQ  = 2'b01,
    SVC_DMA0 = 2'b10,
    SVC_DMA1 = 2'b11
  } svcMode_e;

  // control -> datapath routing strobes
  typedef struct packed {
    logic       txIrqEn;
    logic       rxIrqEn;
    logic [1:0] txDmaEn;
    logic [1:0] rxDmaEn;
    logic       rxTimeout;
  } routeStrobe_t;

  // datapath -> control receive level flags
  typedef struct packed {
    logic rxEmpty;
    logic rxUnderTrig;
  } rxFlags_t;

endpackage

// File: rtl/uart_rr_ctrl.sv
module uart_rr_ctrl
  import uart_rr_pkg::*;
#(
  parameter int TIMEOUT_WORDS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [1:0]   cfgTxMode,
  input  logic [1:0]   cfgRxMode,
  input  logic         wordTick,
  input  logic         rxStrobe,
  input  logic         rxFifoReset,
  input  rxFlags_t     rxFlags,
  output routeStrobe_t route,
  output logic         cfgErr
);
  localparam int CNT_W = $clog2(TIMEOUT_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_WORDS - 1);

  svcMode_e txMode, rxMode;
  logic [CNT_W-1:0] wordCnt;
  logic pending;
  logic clash, newClash;

  assign newClash = cfgTxMode[1] && (cfgTxMode == cfgRxMode);
  assign clash    = txMode[1] && (txMode == rxMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txMode <= SVC_OFF;
      rxMode <= SVC_OFF;
      cfgErr <= 1'b0;
    end else if (cfgWrEn) begin
      txMode <= svcMode_e'(cfgTxMode);
      rxMode <= svcMode_e'(cfgRxMode);
      cfgErr <= newClash;
    end
  end

  logic rxIrqMode, clearAll, countOn;
  assign rxIrqMode = (rxMode == SVC_IRQ);
  assign clearAll  = rxFifoReset || rxStrobe || rxFlags.rxEmpty || !rxIrqMode;
  assign countOn   = rxFlags.rxUnderTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt <= '0;
      pending <= 1'b0;
    end else if (clearAll) begin
      wordCnt <= '0;
      pending <= 1'b0;
    end else if (!countOn) begin
      wordCnt <= '0;
    end else if (wordTick) begin
      if (wordCnt == CNT_LAST) begin
        wordCnt <= '0;
        pending <= 1'b1;
      end else begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  assign route.txIrqEn   = (txMode == SVC_IRQ);
  assign route.rxIrqEn   = rxIrqMode;
  assign route.rxTimeout = pending;

  for (genvar g = 0; g < 2; g++) begin : g_line
    assign route.txDmaEn[g] = (txMode == svcMode_e'(2'b10 | 2'(g))) && !clash;
    assign route.rxDmaEn[g] = (rxMode == svcMode_e'(2'b10 | 2'(g))) && !clash;
  end

  p_line_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({route.txDmaEn[0], route.rxDmaEn[0]}) <= 1 &&
    $countones({route.txDmaEn[1], route.rxDmaEn[1]}) <= 1);

  p_fifo_reset_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoReset |=> !route.rxTimeout);

  p_strobe_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> !route.rxTimeout);

  p_mode_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    !route.rxIrqEn |=> !route.rxTimeout);

endmodule

// File: rtl/uart_rr_datapath.sv
module uart_rr_datapath
  import uart_rr_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txTrig,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrig,
  input  logic             rxFifoReset,
  input  routeStrobe_t     route,
  output rxFlags_t         rxFlags,
  output logic             txIrq,
  output logic             rxIrq,
  output logic [1:0]       dmaReq
);
  logic [LVL_W-1:0] rxEff;
  logic txNeed, rxNeed;

  assign rxEff  = rxFifoReset ? '0 : rxLevel;
  assign txNeed = (txLevel <= txTrig);
  assign rxNeed = (rxEff >= rxTrig);

  assign rxFlags.rxEmpty     = (rxEff == '0);
  assign rxFlags.rxUnderTrig = !rxNeed;

  assign txIrq = route.txIrqEn && txNeed;
  assign rxIrq = route.rxIrqEn && (rxNeed || route.rxTimeout);

  for (genvar g = 0; g < 2; g++) begin : g_req
    assign dmaReq[g] = (route.txDmaEn[g] && txNeed) || (route.rxDmaEn[g] && rxNeed);
  end

  p_tx_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (txLevel <= txTrig));

  p_dma_no_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (route.txDmaEn != 2'b00) |-> !txIrq);

endmodule

// File: rtl/uart_req_router.sv
module uart_req_router
  import uart_rr_pkg::*;
#(
  parameter int LVL_W         = 5,
  parameter int TIMEOUT_WORDS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgTxMode,
  input  logic [1:0]       cfgRxMode,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txTrig,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrig,
  input  logic             wordTick,
  input  logic             rxStrobe,
  input  logic             rxFifoReset,
  output logic             txIrq,
  output logic             rxIrq,
  output logic [1:0]       dmaReq,
  output logic             cfgErr
);
  routeStrobe_t route;
  rxFlags_t     rxFlags;

  uart_rr_ctrl #(.TIMEOUT_WORDS(TIMEOUT_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTxMode(cfgTxMode),
    .cfgRxMode(cfgRxMode), .wordTick(wordTick), .rxStrobe(rxStrobe),
    .rxFifoReset(rxFifoReset), .rxFlags(rxFlags), .route(route), .cfgErr(cfgErr)
  );

  uart_rr_datapath #(.LVL_W(LVL_W)) dp_i (
    .clk(clk), .rstN(rstN), .txLevel(txLevel), .txTrig(txTrig),
    .rxLevel(rxLevel), .rxTrig(rxTrig), .rxFifoReset(rxFifoReset),
    .route(route), .rxFlags(rxFlags), .txIrq(txIrq), .rxIrq(rxIrq), .dmaReq(dmaReq)
  );

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (dmaReq == 2'b00));

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!route.rxIrqEn && route.rxDmaEn == 2'b00 && !route.txIrqEn && route.txDmaEn == 2'b00)
      |-> (!txIrq && !rxIrq && dmaReq == 2'b00));

endmodule

// File: tb/uart_req_router_tb.sv
module uart_req_router_tb_top;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, wordTick = 0, rxStrobe = 0, rxFifoReset = 0;
  logic [1:0] cfgTxMode = 0, cfgRxMode = 0;
  logic [LW-1:0] txLevel = 0, txTrig = 0, rxLevel = 0, rxTrig = 0;
  logic txIrq, rxIrq, cfgErr;
  logic [1:0] dmaReq;

  int errors = 0, checks = 0;
  string curReq = "R1";

  // behavioural model state
  int mTx = 0, mRx = 0, mCnt = 0;
  bit mErr = 0, mPend = 0;

  always #2 clk = ~clk;

  uart_req_router #(.LVL_W(LW), .TIMEOUT_WORDS(3)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTxMode(cfgTxMode),
    .cfgRxMode(cfgRxMode), .txLevel(txLevel), .txTrig(txTrig),
    .rxLevel(rxLevel), .rxTrig(rxTrig), .wordTick(wordTick),
    .rxStrobe(rxStrobe), .rxFifoReset(rxFifoReset), .txIrq(txIrq),
    .rxIrq(rxIrq), .dmaReq(dmaReq), .cfgErr(cfgErr)
  );

  function automatic int effRx();
    return rxFifoReset ? 0 : int'(rxLevel);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // model update at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mTx = 0; mRx = 0; mErr = 0; mCnt = 0; mPend = 0;
    end else begin
      int e;
      e = effRx();
      if (rxFifoReset || rxStrobe || e == 0 || mRx != 1) begin
        mCnt = 0; mPend = 0;
      end else if (e >= int'(rxTrig)) begin
        mCnt = 0;
      end else if (wordTick) begin
        mCnt = mCnt + 1;
        if (mCnt == 3) begin mCnt = 0; mPend = 1; end
      end
      if (cfgWrEn) begin
        mTx = cfgTxMode; mRx = cfgRxMode;
        mErr = (cfgTxMode == cfgRxMode) && cfgTxMode[1];
      end
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      bit tc, rc, eTx, eRx;
      bit [1:0] eDma;
      tc = int'(txLevel) <= int'(txTrig);
      rc = effRx() >= int'(rxTrig);
      eTx = (mTx == 1) && tc;
      eRx = (mRx == 1) && (rc || mPend);
      for (int k = 0; k < 2; k++)
        eDma[k] = !(mTx == mRx) && (((mTx == 2 + k) && tc) || ((mRx == 2 + k) && rc));
      chk(curReq, "txIrq", txIrq, eTx);
      chk(curReq, "rxIrq", rxIrq, eRx);
      chk(curReq, "dmaReq", dmaReq, eDma);
      chk(curReq, "cfgErr", cfgErr, mErr);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic setModes(int t, int r);
    cfgTxMode = 2'(t); cfgRxMode = 2'(r); cfgWrEn = 1;
    step();
    cfgWrEn = 0;
  endtask

  task automatic tick();
    wordTick = 1; step(); wordTick = 0;
  endtask

  task automatic strobe();
    rxStrobe = 1; step(); rxStrobe = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1 reset state
    txLevel = 3; txTrig = 8; rxLevel = 9; rxTrig = 4;
    step();
    chk("R1", "txIrq", txIrq, 0); chk("R1", "rxIrq", rxIrq, 0);
    chk("R1", "dmaReq", dmaReq, 0); chk("R1", "cfgErr", cfgErr, 0);

    // R2 disabled direction with active levels
    curReq = "R2";
    setModes(0, 1);
    txLevel = 0; step();
    chk("R2", "txIrq off", txIrq, 0); chk("R2", "dma off", dmaReq, 0);

    // R3 tx interrupt boundary
    curReq = "R3";
    setModes(1, 0);
    txTrig = 6; txLevel = 6; step(); chk("R3", "tx at trig", txIrq, 1);
    txLevel = 7; step(); chk("R3", "tx above trig", txIrq, 0);
    txLevel = 0; step(); chk("R3", "tx empty", txIrq, 1);

    // R4 rx interrupt boundary
    curReq = "R4";
    setModes(0, 1);
    rxTrig = 4; rxLevel = 4; step(); chk("R4", "rx at trig", rxIrq, 1);
    rxLevel = 3; step(); chk("R4", "rx below trig", rxIrq, 0);

    // R5 legal DMA pairings
    curReq = "R5";
    setModes(2, 3);
    txLevel = 2; rxLevel = 5; step();
    chk("R5", "dma both", dmaReq, 3); chk("R5", "no irq", {txIrq, rxIrq}, 0);
    txLevel = 9; rxLevel = 1; step(); chk("R5", "dma none", dmaReq, 0);
    setModes(3, 2);
    txLevel = 1; step(); chk("R5", "tx on line1", dmaReq, 2);

    // R6 clash
    curReq = "R6";
    rxLevel = 6; setModes(2, 2);
    chk("R6", "err set", cfgErr, 1); chk("R6", "line quiet", dmaReq, 0);
    step(); chk("R6", "err sticky", cfgErr, 1);
    setModes(2, 3);
    chk("R6", "err cleared", cfgErr, 0); chk("R6", "lines back", dmaReq, 3);

    // R7 timeout after three ticks
    curReq = "R7";
    setModes(0, 1);
    rxTrig = 4; rxLevel = 2; step();
    tick(); tick(); chk("R7", "two ticks", rxIrq, 0);
    step(); chk("R7", "idle no tick", rxIrq, 0);
    tick(); chk("R7", "third tick", rxIrq, 1);

    // R9 clear by strobe, then by empty
    curReq = "R9";
    strobe(); chk("R9", "strobe clears", rxIrq, 0);
    tick(); tick(); tick(); chk("R9", "re-fired", rxIrq, 1);
    rxLevel = 0; step(); chk("R9", "empty clears", rxIrq, 0);
    rxLevel = 2; step(); chk("R9", "stays clear", rxIrq, 0);

    // R8 restart on word
    curReq = "R8";
    strobe();
    tick(); tick(); strobe(); tick(); tick();
    chk("R8", "restarted", rxIrq, 0);
    tick(); chk("R8", "third after restart", rxIrq, 1);

    // R10 fifo reset
    curReq = "R10";
    rxFifoReset = 1; step();
    chk("R10", "cleared in reset", rxIrq, 0);
    rxFifoReset = 0; step(); chk("R10", "after reset", rxIrq, 0);
    tick(); tick(); rxFifoReset = 1; rxLevel = 7; step();
    chk("R10", "level masked", rxIrq, 0);
    rxFifoReset = 0; rxLevel = 2; step();
    tick(); chk("R10", "count cleared", rxIrq, 0);

    // R11 no timeout outside interrupt mode
    curReq = "R11";
    setModes(0, 2);
    rxLevel = 2;
    for (int i = 0; i < 5; i++) tick();
    chk("R11", "dma no timeout", dmaReq, 0);
    setModes(0, 1);
    chk("R11", "irq after switch", rxIrq, 0);

    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule